// File: doc/BRIEF.md
# Register-Mapped 32-bit Adder with AXI4-Lite Access

This block puts a 32-bit adder behind a small memory-mapped register set that a processor reaches over AXI4-Lite. Software loads the two operands into their registers. It then writes a start bit into the control word. One clock later the sum sits in a read-only result register. The control word also shows the core's status: a done flag that clears when read, and idle and ready flags.

The block decodes a 64 KiB address window. The control word is at 0x00, operand A at 0x10, operand B at 0x18 and the result at 0x20. Any other offset in the window reads as zero, and a write to it has no effect. The write address and write data may arrive in either order. Only one write and one read are in flight at a time.

Top module: `sum_axil`

## Requirements
- R1: After reset, operand A (0x10), operand B (0x18) and result (0x20) read 0, and the control word (0x00) reads 0x0000000C (idle and ready set, start and done clear).
- R2: Operand A at 0x10 and operand B at 0x18 are 32-bit read/write registers that read back the value last written.
- R3: A write to A or B updates only the byte lanes whose WSTRB bit is 1. WSTRB bit i covers data bits 8i+7 to 8i.
- R4: A write to 0x00 with WSTRB bit 0 set and data bit 0 equal to 1 starts a computation. One cycle later, the result at 0x20 holds (A+B) mod 2^32. A read of the result issued after that write's response returns the sum without any polling.
- R5: The start bit (control bit 0) clears itself once the core takes the operation, so it reads 0 after a completed computation. A control write with data bit 0 equal to 0, or with WSTRB bit 0 clear, starts nothing.
- R6: The done bit (control bit 1) is set when a computation completes. A read of the control word returns it as 1 and clears it, so the next read returns 0.
- R7: The idle bit (control bit 2) and the ready bit (control bit 3) read 1 whenever no computation is pending.
- R8: The write address and write data are accepted in any order: address first, data first, or both in the same cycle.
- R9: BRESP and RRESP are always 2'b00 (OKAY).
- R10: Writes to the result register and to unused offsets are ignored. Unused offsets (for example 0x04 and 0x14) read 0.
- R11: BVALID and RVALID stay high until accepted, and RDATA holds steady while RVALID waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| awaddr | input | 16 | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte enables |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| bresp | output | 2 | Write response, always OKAY |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response accepted by the master |
| araddr | input | 16 | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response, always OKAY |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data accepted by the master |

## Verification
The assertions check the following on every cycle:
- the start bit lasts exactly one cycle;
- done rises in the cycle after start;
- the result equals the sum of the operands held when start was set;
- a write commit never repeats in back-to-back cycles;
- both responses stay valid and steady until the master takes them.

Only the bench's scenarios can show the rest:
- byte-lane merging;
- the three channel orderings;
- the clear-on-read of done;
- the silence of the result register and of unused offsets;
- the wrap of the 32-bit sum.

// File: rtl/sum_axil_pkg.sv
// Shared constants for the register-mapped adder.
// Assumes a byte-addressed window; offsets are byte offsets.
package sum_axil_pkg;
    localparam int OFF_CTRL = 'h00;
    localparam int OFF_OPA  = 'h10;
    localparam int OFF_OPB  = 'h18;
    localparam int OFF_SUM  = 'h20;

    // Control word bit positions (software decodes these)
    localparam int CB_START = 0;
    localparam int CB_DONE  = 1;
    localparam int CB_IDLE  = 2;
    localparam int CB_READY = 3;

    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/sum_axil_wr.sv
// Write-side channel handling: holds the address and the data beat in separate
// one-entry slots, so they may arrive in any order. When both slots are full
// and no response is pending, it issues a one-cycle commit and raises BVALID.
// Assumes a single outstanding write.
module sum_axil_wr #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    output logic              commit,
    output logic [ADDR_W-1:0] c_addr,
    output logic [DATA_W-1:0] c_data,
    output logic [STRB_W-1:0] c_strb
);
    logic              aw_full_q, w_full_q, bvalid_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [STRB_W-1:0] strb_q;

    // Slot readiness and commit condition
    always_comb begin
        awready = !aw_full_q;
        wready  = !w_full_q;
        commit  = aw_full_q && w_full_q && !bvalid_q;
    end

    assign bvalid = bvalid_q;
    assign c_addr = addr_q;
    assign c_data = data_q;
    assign c_strb = strb_q;

    // Slot capture, commit release and response hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_full_q <= 1'b0;
            w_full_q  <= 1'b0;
            bvalid_q  <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
            strb_q    <= '0;
        end else begin
            if (awvalid && !aw_full_q) begin
                aw_full_q <= 1'b1;
                addr_q    <= awaddr;
            end
            if (wvalid && !w_full_q) begin
                w_full_q <= 1'b1;
                data_q   <= wdata;
                strb_q   <= wstrb;
            end
            if (commit) begin
                aw_full_q <= 1'b0;
                w_full_q  <= 1'b0;
                bvalid_q  <= 1'b1;
            end else if (bvalid_q && bready) begin
                bvalid_q <= 1'b0;
            end
        end
    end

    // R8: a commit frees both slots and raises BVALID, so it cannot repeat at once
    p_single_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
    // R11: response held until taken
    p_bvalid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);
endmodule

// File: rtl/sum_axil_rd.sv
// Read-side channel handling: takes one address when no data is waiting,
// registers the decoded word, and holds RVALID/RDATA until the master
// accepts them. Assumes a single outstanding read.
module sum_axil_rd #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arvalid,
    output logic              arready,
    output logic              fire,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    input  logic              rready
);
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;

    // Accept a new address only while no data is waiting
    always_comb begin
        arready = !rvalid_q;
        fire    = arvalid && !rvalid_q;
    end

    assign rvalid = rvalid_q;
    assign rdata  = rdata_q;

    // Data capture and hold until accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (fire) begin
            rvalid_q <= 1'b1;
            rdata_q  <= word_in;
        end else if (rvalid_q && rready) begin
            rvalid_q <= 1'b0;
        end
    end

    // R11: read data valid and steady until taken
    p_rvalid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));
endmodule

// File: rtl/sum_axil_core.sv
// Register set and adder. Operands merge writes per byte lane. A start
// request lives for one cycle; on the following edge the sum is latched and
// done is set. A read of the control word clears done, but a completion in
// the same cycle wins. Assumes commit and read pulses last one cycle.
module sum_axil_core
    import sum_axil_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_OPA  = ADDR_W'(OFF_OPA);
    localparam logic [ADDR_W-1:0] A_OPB  = ADDR_W'(OFF_OPB);
    localparam logic [ADDR_W-1:0] A_SUM  = ADDR_W'(OFF_SUM);

    logic [DATA_W-1:0] opa_q, opb_q, sum_q;
    logic [DATA_W-1:0] opa_nx, opb_nx;
    logic              start_q, done_q;
    logic [DATA_W-1:0] ctrl_word;

    // Byte-lane merge of incoming data into each operand
    for (genvar i = 0; i < STRB_W; i++) begin : g_lane
        assign opa_nx[8*i +: 8] = wr_strb[i] ? wr_data[8*i +: 8] : opa_q[8*i +: 8];
        assign opb_nx[8*i +: 8] = wr_strb[i] ? wr_data[8*i +: 8] : opb_q[8*i +: 8];
    end

    // Control word assembly
    always_comb begin
        ctrl_word           = '0;
        ctrl_word[CB_START] = start_q;
        ctrl_word[CB_DONE]  = done_q;
        ctrl_word[CB_IDLE]  = !start_q;
        ctrl_word[CB_READY] = !start_q;
    end

    // Read decode; unmatched offsets return zero
    always_comb begin
        if (rd_addr == A_CTRL)     rd_word = ctrl_word;
        else if (rd_addr == A_OPA) rd_word = opa_q;
        else if (rd_addr == A_OPB) rd_word = opb_q;
        else if (rd_addr == A_SUM) rd_word = sum_q;
        else                       rd_word = '0;
    end

    // Operand register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_OPA) opa_q <= opa_nx;
            if (wr_addr == A_OPB) opb_q <= opb_nx;
        end
    end

    // Start, sum and done sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            sum_q   <= '0;
        end else begin
            if (rd_en && rd_addr == A_CTRL) done_q <= 1'b0;
            if (start_q) begin
                sum_q   <= opa_q + opb_q;
                start_q <= 1'b0;
                done_q  <= 1'b1;
            end else if (wr_en && wr_addr == A_CTRL && wr_strb[0] && wr_data[CB_START]) begin
                start_q <= 1'b1;
            end
        end
    end

    // R5: the start request clears itself after one cycle
    p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
    // R6: completion raises done
    p_done_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> done_q);
    // R4: result equals the operands held at start
    p_sum_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> sum_q == $past(opa_q) + $past(opb_q));
endmodule

// File: rtl/sum_axil.sv
// Top level: AXI4-Lite slave fronting the adder register set. Both
// responses are always OKAY. Assumes a 64 KiB window, so addresses are 16 bits.
module sum_axil
    import sum_axil_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready
);
    logic              commit, rd_fire;
    logic [ADDR_W-1:0] c_addr;
    logic [DATA_W-1:0] c_data, rd_word;
    logic [STRB_W-1:0] c_strb;

    assign bresp = RESP_OKAY;
    assign rresp = RESP_OKAY;

    sum_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bvalid(bvalid), .bready(bready),
        .commit(commit), .c_addr(c_addr), .c_data(c_data), .c_strb(c_strb)
    );

    sum_axil_rd #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .arvalid(arvalid), .arready(arready), .fire(rd_fire),
        .word_in(rd_word), .rdata(rdata), .rvalid(rvalid), .rready(rready)
    );

    sum_axil_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit), .wr_addr(c_addr), .wr_data(c_data), .wr_strb(c_strb),
        .rd_en(rd_fire), .rd_addr(araddr), .rd_word(rd_word)
    );
endmodule

// File: tb/sim_sum_axil.sv
`timescale 1ns/1ps
// Directed bench for sum_axil: one task per scenario, each checking its own results.
module sim_sum_axil;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] awaddr = '0, araddr = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0;
    logic        arvalid = 1'b0, rready = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sum_axil u0 (
        .clk(clk), .rst_n(rst_n),
        .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .araddr(araddr), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // mode 0: address and data together, 1: address first, 2: data first
    task automatic axi_wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s, input int mode);
        bit aw_done = 0, w_done = 0, aw_f, w_f;
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; bready = 1'b1;
        awvalid = (mode != 2);
        wvalid  = (mode != 1);
        while (!(aw_done && w_done)) begin
            aw_f = awvalid && awready;
            w_f  = wvalid && wready;
            @(negedge clk);
            if (aw_f) begin awvalid = 1'b0; aw_done = 1; end
            if (w_f)  begin wvalid = 1'b0;  w_done = 1; end
            if (aw_done && !w_done && !wvalid) wvalid = 1'b1;
            if (w_done && !aw_done && !awvalid) awvalid = 1'b1;
        end
        while (!bvalid) @(negedge clk);
        chk(bresp == 2'b00, "R9 bresp", 32'(bresp), 0);
        @(negedge clk);
        bready = 1'b0;
    endtask

    task automatic axi_rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        // R11: hold rready low for a cycle and confirm data stays put
        while (!rvalid) @(negedge clk);
        d = rdata;
        @(negedge clk);
        chk(rvalid && rdata == d, "R11 rvalid hold", rdata, d);
        chk(rresp == 2'b00, "R9 rresp", 32'(rresp), 0);
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        axi_rd(16'h0000, v); chk(v == 32'hC, "R1 ctrl reset", v, 32'hC);
        axi_rd(16'h0010, v); chk(v == 0, "R1 A reset", v, 0);
        axi_rd(16'h0018, v); chk(v == 0, "R1 B reset", v, 0);
        axi_rd(16'h0020, v); chk(v == 0, "R1 Y reset", v, 0);
    endtask

    task automatic t_orders();
        logic [31:0] v;
        axi_wr(16'h0010, 32'hDEADBEEF, 4'hF, 0);
        axi_rd(16'h0010, v); chk(v == 32'hDEADBEEF, "R2 R8 A same cycle", v, 32'hDEADBEEF);
        axi_wr(16'h0018, 32'h01234567, 4'hF, 1);
        axi_rd(16'h0018, v); chk(v == 32'h01234567, "R2 R8 B addr first", v, 32'h01234567);
        axi_wr(16'h0010, 32'h89ABCDEF, 4'hF, 2);
        axi_rd(16'h0010, v); chk(v == 32'h89ABCDEF, "R2 R8 A data first", v, 32'h89ABCDEF);
    endtask

    task automatic t_strobe();
        logic [31:0] v;
        axi_wr(16'h0010, 32'h11223344, 4'hF, 0);
        axi_wr(16'h0010, 32'hAABBCCDD, 4'b0101, 0);
        axi_rd(16'h0010, v); chk(v == 32'h11BB33DD, "R3 A lanes", v, 32'h11BB33DD);
        axi_wr(16'h0018, 32'h00000000, 4'hF, 0);
        axi_wr(16'h0018, 32'hFFFFFFFF, 4'b1000, 1);
        axi_rd(16'h0018, v); chk(v == 32'hFF000000, "R3 B top lane", v, 32'hFF000000);
    endtask

    task automatic t_add();
        logic [31:0] v;
        axi_wr(16'h0010, 32'd7, 4'hF, 0);
        axi_wr(16'h0018, 32'd12, 4'hF, 0);
        axi_wr(16'h0000, 32'h1, 4'h1, 0);
        axi_rd(16'h0020, v); chk(v == 32'd19, "R4 sum", v, 32'd19);
        axi_wr(16'h0010, 32'hFFFFFFFF, 4'hF, 2);
        axi_wr(16'h0018, 32'd2, 4'hF, 1);
        axi_wr(16'h0000, 32'h1, 4'h1, 0);
        axi_rd(16'h0020, v); chk(v == 32'd1, "R4 wrap", v, 32'd1);
    endtask

    task automatic t_status();
        logic [31:0] v;
        axi_rd(16'h0000, v); chk(v == 32'hE, "R5 R6 R7 ctrl after run", v, 32'hE);
        axi_rd(16'h0000, v); chk(v == 32'hC, "R6 done cleared by read", v, 32'hC);
        axi_wr(16'h0010, 32'd100, 4'hF, 0);
        axi_wr(16'h0000, 32'h0, 4'hF, 0);
        axi_wr(16'h0000, 32'h1, 4'h2, 0);
        axi_rd(16'h0000, v); chk(v == 32'hC, "R5 no start", v, 32'hC);
        axi_rd(16'h0020, v); chk(v == 32'd1, "R5 sum unchanged", v, 32'd1);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        axi_wr(16'h0020, 32'h55555555, 4'hF, 0);
        axi_rd(16'h0020, v); chk(v == 32'd1, "R10 Y write ignored", v, 32'd1);
        axi_wr(16'h0004, 32'h12345678, 4'hF, 0);
        axi_rd(16'h0004, v); chk(v == 0, "R10 unused 0x04", v, 0);
        axi_wr(16'h0014, 32'hCAFEF00D, 4'hF, 1);
        axi_rd(16'h0014, v); chk(v == 0, "R10 unused 0x14", v, 0);
        axi_rd(16'h0010, v); chk(v == 32'd100, "R10 A untouched", v, 32'd100);
        axi_rd(16'h0018, v); chk(v == 32'd2, "R10 B untouched", v, 32'd2);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_orders();
        t_strobe();
        t_add();
        t_status();
        t_ignored();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule